// File: doc/BRIEF.md
# Two-Output Level Interrupt Controller

This block collects 32 or, by parameter, 64 level-sensitive, active-high interrupt sources and steers each one to one of two processor outputs: a normal interrupt line (`irq_o`) and a fast interrupt line (`fiq_o`). Every source has its own mask bit and its own routing bit. Software sees the synchronised raw levels, one masked status word per output, and a per-output word that names the lowest-numbered active source. All of this sits behind a plain 32-bit register port with a byte address inside a 256-byte window.

Source inputs pass through a two-flop synchroniser. Pending state is never stored: a pending bit is the synchronised input level, so it falls only when the source drops its request. Writes cannot clear it. The 64-source build adds an upper register bank for sources 32 to 63. In the 32-source build that bank reads as zero and ignores writes.

Top module: `dual_line_intc`

## Requirements
- R1: After reset every mask bit and routing bit is 0, `irq_o` and `fiq_o` are low, and every register reads 0 while no source is asserted.
- R2: Raw status (word offset 0x00 for sources 0-31, 0x20 for 32-63) equals the source levels delayed by two clock edges. A pending bit falls only when its input falls. A write to a raw status register has no effect.
- R3: Enable registers (0x04 lower, 0x24 upper) read back as written. A 1 passes its source through. Clearing one bit masks only that source.
- R4: Select registers (0x08 lower, 0x28 upper) read back as written. A select value of 0 routes the source to the normal output and 1 routes it to the fast output. Normal status (0x0C, 0x2C) bit i = pending & enabled & not selected. Fast status (0x10, 0x30) bit i = pending & enabled & selected.
- R5: `irq_o` is the registered OR of all normal-status bits, and `fiq_o` is the registered OR of all fast-status bits. Each follows its status with one register stage.
- R6: The word at 0x18 (normal) and the word at 0x1C (fast) give the index of the lowest-numbered active source for that output in bits [5:0], with bit 31 set as a valid flag. The word reads all zeros when no source is active.
- R7: The priority word at 0x14, and in the 64-source build the error-enable word at 0x34, read back as written. Neither one changes status or the highest-pending words.
- R8: With `NUM_SRC` = 32, offsets 0x20 to 0x34 read 0 and ignore writes.
- R9: Unmapped offsets (0x38 to 0xFC) read 0 and ignore writes. Writes to status and highest-pending words have no effect.
- R10: `reg_rdata_o` shows the register addressed in the previous cycle. It changes only at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive, active-high interrupt requests |
| reg_addr_i | input | 8 | Byte address within the register window (bits [1:0] ignored) |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The assertions take for granted that `rst_ni` is driven cleanly around clock edges and that `src_i` is sampled by the synchroniser as settled values. The pending-tracking check compares against the input two edges earlier, which holds only when the input is not metastable. The bench changes `src_i`, the address and the strobe only at falling clock edges. It holds each source pattern for several cycles before it samples, so every level crosses both synchroniser flops and the output register before it is checked.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int MAX_SRC = 64;
    localparam int IDX_W   = 6;

    // word offsets (byte address [7:2])
    localparam logic [5:0] W_RAW_LO = 6'd0;
    localparam logic [5:0] W_EN_LO  = 6'd1;
    localparam logic [5:0] W_SEL_LO = 6'd2;
    localparam logic [5:0] W_IST_LO = 6'd3;
    localparam logic [5:0] W_FST_LO = 6'd4;
    localparam logic [5:0] W_PRIO   = 6'd5;
    localparam logic [5:0] W_HP_IRQ = 6'd6;
    localparam logic [5:0] W_HP_FIQ = 6'd7;
    localparam logic [5:0] W_RAW_HI = 6'd8;
    localparam logic [5:0] W_EN_HI  = 6'd9;
    localparam logic [5:0] W_SEL_HI = 6'd10;
    localparam logic [5:0] W_IST_HI = 6'd11;
    localparam logic [5:0] W_FST_HI = 6'd12;
    localparam logic [5:0] W_ERR_HI = 6'd13;

    typedef struct packed {
        logic [MAX_SRC-1:0] en;
        logic [MAX_SRC-1:0] sel;
        logic [31:0]        prio;
        logic [31:0]        errhi;
        logic [31:0]        rdata;
        logic               irq;
        logic               fiq;
    } intc_state_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_first_set.sv
module intc_first_set #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [7:0]         reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam bit HAS_HI = (NUM_SRC == MAX_SRC);

    initial begin
        if (NUM_SRC != 32 && NUM_SRC != 64)
            $error("NUM_SRC must be 32 or 64");
    end

    intc_state_t st_d, st_q;

    logic [NUM_SRC-1:0] pend;
    logic [MAX_SRC-1:0] pend64;
    logic [MAX_SRC-1:0] irq_st, fiq_st;
    logic               hp_irq_v, hp_fiq_v;
    logic [IDX_W-1:0]   hp_irq_idx, hp_fiq_idx;
    logic [31:0]        hp_irq_word, hp_fiq_word;
    logic [5:0]         word;

    intc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (src_i),
        .q_o   (pend)
    );

    assign pend64 = MAX_SRC'(pend);
    assign irq_st = pend64 & st_q.en & ~st_q.sel;
    assign fiq_st = pend64 & st_q.en &  st_q.sel;

    intc_first_set #(.W(MAX_SRC), .IW(IDX_W)) u_hp_irq (
        .vec_i  (irq_st),
        .found_o(hp_irq_v),
        .idx_o  (hp_irq_idx)
    );

    intc_first_set #(.W(MAX_SRC), .IW(IDX_W)) u_hp_fiq (
        .vec_i  (fiq_st),
        .found_o(hp_fiq_v),
        .idx_o  (hp_fiq_idx)
    );

    assign hp_irq_word = {hp_irq_v, 25'd0, hp_irq_idx};
    assign hp_fiq_word = {hp_fiq_v, 25'd0, hp_fiq_idx};
    assign word        = reg_addr_i[7:2];

    always_comb begin
        st_d = st_q;

        if (reg_wr_i) begin
            unique case (word)
                W_EN_LO:  st_d.en[31:0]   = reg_wdata_i;
                W_SEL_LO: st_d.sel[31:0]  = reg_wdata_i;
                W_PRIO:   st_d.prio       = reg_wdata_i;
                W_EN_HI:  if (HAS_HI) st_d.en[63:32]  = reg_wdata_i;
                W_SEL_HI: if (HAS_HI) st_d.sel[63:32] = reg_wdata_i;
                W_ERR_HI: if (HAS_HI) st_d.errhi      = reg_wdata_i;
                default: ;
            endcase
        end

        st_d.rdata = '0;
        unique case (word)
            W_RAW_LO: st_d.rdata = pend64[31:0];
            W_EN_LO:  st_d.rdata = st_q.en[31:0];
            W_SEL_LO: st_d.rdata = st_q.sel[31:0];
            W_IST_LO: st_d.rdata = irq_st[31:0];
            W_FST_LO: st_d.rdata = fiq_st[31:0];
            W_PRIO:   st_d.rdata = st_q.prio;
            W_HP_IRQ: st_d.rdata = hp_irq_word;
            W_HP_FIQ: st_d.rdata = hp_fiq_word;
            W_RAW_HI: if (HAS_HI) st_d.rdata = pend64[63:32];
            W_EN_HI:  if (HAS_HI) st_d.rdata = st_q.en[63:32];
            W_SEL_HI: if (HAS_HI) st_d.rdata = st_q.sel[63:32];
            W_IST_HI: if (HAS_HI) st_d.rdata = irq_st[63:32];
            W_FST_HI: if (HAS_HI) st_d.rdata = fiq_st[63:32];
            W_ERR_HI: if (HAS_HI) st_d.rdata = st_q.errhi;
            default: ;
        endcase

        st_d.irq = |irq_st;
        st_d.fiq = |fiq_st;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign reg_rdata_o = st_q.rdata;
    assign irq_o       = st_q.irq;
    assign fiq_o       = st_q.fiq;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int NUM_SRC = 64
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_i,
    input logic [63:0]        pend64,
    input logic [63:0]        irq_st,
    input logic [63:0]        fiq_st,
    input logic [63:0]        en_q,
    input logic [31:0]        hp_irq_word,
    input logic [31:0]        hp_fiq_word,
    input logic [7:0]         reg_addr_i,
    input logic               reg_wr_i,
    input logic [31:0]        reg_rdata_o,
    input logic               irq_o,
    input logic               fiq_o
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cyc_q <= 2'd0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    // R2: pending equals the input two edges earlier
    a_r2_pend_tracks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q >= 2'd2) |-> pend64 == 64'($past(src_i, 2)));

    // R3: enables change only after a write
    a_r3_enable_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q >= 2'd1 && !$past(reg_wr_i)) |-> $stable(en_q));

    // R5 / R6: output line agrees with the encoder's valid flag
    a_r5_irq_matches_hp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q >= 2'd1) |-> irq_o == $past(hp_irq_word[31]));

    a_r5_fiq_matches_hp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q >= 2'd1) |-> fiq_o == $past(hp_fiq_word[31]));

    // R6: reported index is active and no lower index is
    a_r6_irq_index_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hp_irq_word[31] |-> (irq_st[hp_irq_word[5:0]] &&
            ((irq_st & ((64'd1 << hp_irq_word[5:0]) - 64'd1)) == 64'd0)));

    a_r6_fiq_index_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hp_fiq_word[31] |-> (fiq_st[hp_fiq_word[5:0]] &&
            ((fiq_st & ((64'd1 << hp_fiq_word[5:0]) - 64'd1)) == 64'd0)));

    // R9: unmapped offsets read zero
    a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q >= 2'd1 && $past(reg_addr_i[7:2]) > 6'd13) |-> reg_rdata_o == 32'd0);

    // R8: upper enables stay clear in the small build
    if (NUM_SRC == 32) begin : g_small
        a_r8_no_upper_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_q[63:32] == 32'd0);
    end
endmodule

bind dual_line_intc intc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .pend64     (pend64),
    .irq_st     (irq_st),
    .fiq_st     (fiq_st),
    .en_q       (st_q.en),
    .hp_irq_word(hp_irq_word),
    .hp_fiq_word(hp_fiq_word),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o)
);

// File: tb/dual_line_intc_bench.sv
`timescale 1ns/1ps
module dual_line_intc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    logic [31:0] src_s = '0;
    logic [7:0]  addr_s = '0;
    logic        wr_s = 1'b0;
    logic [31:0] wdata_s = '0;
    logic [31:0] rdata_s;
    logic        irq_s, fiq_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_line_intc #(.NUM_SRC(64)) u_dual_line_intc (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    dual_line_intc #(.NUM_SRC(32)) u_dual_line_intc_n32 (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src_s), .reg_addr_i(addr_s),
        .reg_wr_i(wr_s), .reg_wdata_i(wdata_s), .reg_rdata_o(rdata_s),
        .irq_o(irq_s), .fiq_o(fiq_s)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] en;
        logic [31:0] sel;
        logic [31:0] ist;
        logic [31:0] fst;
        logic [31:0] hpi;
        logic [31:0] hpf;
        logic        io;
        logic        fo;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_00F0, 32'h0000_00FF, 32'h0000_0030, 32'h0000_00C0, 32'h0000_0030, 32'h8000_0006, 32'h8000_0004, 1'b1, 1'b1},
        '{32'h8000_0001, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_001F, 32'h0000_0000, 1'b1, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h0000_0F00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0F00, 32'h0000_0000, 32'h8000_0008, 1'b0, 1'b1},
        '{32'h1234_5678, 32'hFFFF_0000, 32'h00FF_0000, 32'h1200_0000, 32'h0034_0000, 32'h8000_0019, 32'h8000_0012, 1'b1, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic wr_small(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_s = a; wdata_s = d; wr_s = 1'b1;
        @(negedge clk);
        wr_s = 1'b0;
    endtask

    task automatic rd_small(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_s = a;
        @(negedge clk);
        d = rdata_s;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk("R1 irq_o", {31'd0, irq}, 32'd0);
        chk("R1 fiq_o", {31'd0, fiq}, 32'd0);
        for (int a = 0; a < 14; a++) begin
            rd_reg(8'(a * 4), v);
            chk($sformatf("R1 reset read 0x%02h", a * 4), v, 32'd0);
        end

        // table walk: lower bank (R2 R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            wr_reg(8'h04, VECS[i].en);
            wr_reg(8'h08, VECS[i].sel);
            @(negedge clk);
            src = {32'd0, VECS[i].src};
            settle();
            rd_reg(8'h00, v); chk($sformatf("R2 raw v%0d", i), v, VECS[i].src);
            rd_reg(8'h04, v); chk($sformatf("R3 enable v%0d", i), v, VECS[i].en);
            rd_reg(8'h08, v); chk($sformatf("R4 select v%0d", i), v, VECS[i].sel);
            rd_reg(8'h0C, v); chk($sformatf("R4 irq status v%0d", i), v, VECS[i].ist);
            rd_reg(8'h10, v); chk($sformatf("R4 fiq status v%0d", i), v, VECS[i].fst);
            rd_reg(8'h18, v); chk($sformatf("R6 hp irq v%0d", i), v, VECS[i].hpi);
            rd_reg(8'h1C, v); chk($sformatf("R6 hp fiq v%0d", i), v, VECS[i].hpf);
            chk($sformatf("R5 irq_o v%0d", i), {31'd0, irq}, {31'd0, VECS[i].io});
            chk($sformatf("R5 fiq_o v%0d", i), {31'd0, fiq}, {31'd0, VECS[i].fo});
        end

        // R2: writes cannot clear pending; input drop clears it
        @(negedge clk); src = 64'h0000_0000_0000_0005;
        settle();
        wr_reg(8'h00, 32'h0);
        rd_reg(8'h00, v); chk("R2 raw write ignored", v, 32'h5);
        @(negedge clk); src = 64'h0000_0000_0000_0004;
        settle();
        rd_reg(8'h00, v); chk("R2 pending clears on input drop", v, 32'h4);

        // R5: registered output latency (one edge after status)
        wr_reg(8'h04, 32'h0000_0000);
        wr_reg(8'h08, 32'h0000_0000);
        settle();
        @(negedge clk); addr = 8'h04; wdata = 32'h4; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        chk("R5 irq_o not yet set", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R5 irq_o set one edge later", {31'd0, irq}, 32'd1);

        // R3: masking one source leaves the other
        @(negedge clk); src = 64'h0000_0000_0000_0006;
        wr_reg(8'h04, 32'h6);
        settle();
        wr_reg(8'h04, 32'h4);
        rd_reg(8'h0C, v); chk("R3 masking one source only", v, 32'h4);

        // upper bank (R4 R6)
        @(negedge clk); src = 64'h0000_0100_0000_0000;
        wr_reg(8'h04, 32'h0);
        wr_reg(8'h24, 32'h0000_0100);
        settle();
        rd_reg(8'h20, v); chk("R2 upper raw", v, 32'h0000_0100);
        rd_reg(8'h2C, v); chk("R4 upper irq status", v, 32'h0000_0100);
        rd_reg(8'h18, v); chk("R6 hp irq upper source", v, 32'h8000_0028);
        wr_reg(8'h28, 32'h0000_0100);
        settle();
        rd_reg(8'h30, v); chk("R4 upper fiq status", v, 32'h0000_0100);
        rd_reg(8'h1C, v); chk("R6 hp fiq upper source", v, 32'h8000_0028);
        rd_reg(8'h18, v); chk("R6 hp irq empty", v, 32'h0);
        chk("R5 fiq_o from upper", {31'd0, fiq}, 32'd1);
        chk("R5 irq_o clear", {31'd0, irq}, 32'd0);
        @(negedge clk); src = 64'h0000_0100_0000_0008;
        wr_reg(8'h08, 32'h8);
        wr_reg(8'h04, 32'h8);
        settle();
        rd_reg(8'h1C, v); chk("R6 hp fiq lower wins", v, 32'h8000_0003);

        // R7: priority and error-enable words are storage only
        wr_reg(8'h14, 32'hA5A5_0001);
        wr_reg(8'h34, 32'h0000_00FF);
        rd_reg(8'h14, v); chk("R7 priority readback", v, 32'hA5A5_0001);
        rd_reg(8'h34, v); chk("R7 error enable readback", v, 32'h0000_00FF);
        rd_reg(8'h1C, v); chk("R7 hp fiq unchanged", v, 32'h8000_0003);

        // R9: unmapped and read-only writes
        wr_reg(8'h40, 32'hFFFF_FFFF);
        rd_reg(8'h40, v); chk("R9 unmapped read", v, 32'h0);
        rd_reg(8'hFC, v); chk("R9 top of window", v, 32'h0);
        wr_reg(8'h30, 32'h0);
        wr_reg(8'h1C, 32'h0);
        rd_reg(8'h30, v); chk("R9 status write ignored", v, 32'h0000_0100);
        rd_reg(8'h1C, v); chk("R9 hp write ignored", v, 32'h8000_0003);

        // R10: read data is registered
        @(negedge clk); addr = 8'h14;
        @(negedge clk);
        chk("R10 registered data", rdata, 32'hA5A5_0001);
        addr = 8'h34;
        #1;
        chk("R10 holds until edge", rdata, 32'hA5A5_0001);
        @(negedge clk);
        chk("R10 follows after edge", rdata, 32'h0000_00FF);

        // R8: 32-source build has no upper bank
        wr_small(8'h24, 32'hFFFF_FFFF);
        wr_small(8'h34, 32'hFFFF_FFFF);
        wr_small(8'h04, 32'h1);
        @(negedge clk); src_s = 32'h1;
        settle();
        rd_small(8'h24, v); chk("R8 upper enable absent", v, 32'h0);
        rd_small(8'h34, v); chk("R8 error enable absent", v, 32'h0);
        rd_small(8'h20, v); chk("R8 upper raw absent", v, 32'h0);
        rd_small(8'h18, v); chk("R8 lower bank works", v, 32'h8000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule